// File: doc/BRIEF.md
# SPI Transmit Queue with Paced Word Release

This block feeds the serial shifter of an SPI master. A CPU side writes 16-bit words into a 16-entry queue. A single holding word sits between the queue and the shifter, and the shifter takes that word through a one-cycle load strobe. The holding word is refilled from the queue only once the shifter has reported that the last bit of the previous word is out. After each finished word, a programmable pause of 0 to 255 serial clock ticks runs before the next load. A pause of zero gives continuous, back-to-back transmission.

The queue occupancy is visible on an output at all times. A level-sensitive transmit request is raised whenever that occupancy is at or below a programmable threshold and the request is enabled. A flush control empties the queue, discards the holding word and cancels any pending pause, and stays in force for as long as it is held high.

Top module: `spi_txq`

## Requirements
- R1: While reset is asserted and right after it, `fill_o` is 0 and `ld_o` is 0.
- R2: Every accepted word reaches the shifter exactly once, in write order. A word is presented on `ld_data_o` in the cycle in which `ld_o` is 1.
- R3: A write made while `fill_o` equals 16 is dropped. The count stays at 16, and the dropped word is never sent.
- R4: `fill_o` gives the number of words in the queue. The holding word is not counted. The value never exceeds 16, and it changes by at most one per cycle except during a flush.
- R5: After a load, `ld_o` stays 0 until the shifter pulses `shift_done_i`. The holding word is not refilled while the shifter is busy.
- R6: A `shift_done_i` pulse loads the pause counter from `gap_i`. The counter decrements on each `sclk_tick_i` cycle that follows. The next `ld_o` comes in the first cycle after the counter has reached zero, and never before `gap_i` ticks have been counted.
- R7: With `gap_i` = 0 and a word waiting in the queue, `ld_o` is 1 in the cycle right after the `shift_done_i` pulse.
- R8: While `fifo_clr_i` is 1, writes are ignored and `ld_o` is 0. One cycle later `fill_o` is 0, the holding word is gone and any pending pause is cancelled. The first word written after release is the next word sent.
- R9: With `irq_en_i` = 1, `irq_o` is 1 exactly when `fill_o` <= `trig_lvl_i`, with both compared as unsigned numbers.
- R10: With `irq_en_i` = 0, `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the queue |
| wr_data_i | input | 16 | Word to enqueue |
| fifo_clr_i | input | 1 | Flush queue, holding word and pause while high |
| gap_i | input | 8 | Pause between words, in serial clock ticks |
| trig_lvl_i | input | 5 | Transmit request threshold |
| irq_en_i | input | 1 | Transmit request enable |
| shift_done_i | input | 1 | Shifter pulse: last bit of the word is out |
| sclk_tick_i | input | 1 | One pulse per serial clock cycle |
| ld_o | output | 1 | Load strobe to the shifter |
| ld_data_o | output | 16 | Word handed to the shifter |
| fill_o | output | 5 | Queue occupancy |
| irq_o | output | 1 | Level transmit request |

## Verification
Some properties are checked on every cycle by the assertions. These are the bound on the occupancy and its step of at most one per cycle, the single load per shifted word, the absence of a load right after a non-zero pause is armed, the flush result, and the gating of the request by its enable. Other behaviour can only be shown by the bench scenarios. These are the exact cycle on which a paced word leaves, the order of the words end to end, the loss of overflowing writes, and the restart after a flush that cancelled a long pause. The bench drives a random mix of writes, ticks, flushes and shifter latencies against a reference queue.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_BUSY = 1'b1
  } sh_state_e;

  function automatic int unsigned occ_w(input int unsigned depth);
    return $clog2(depth) + 1;
  endfunction
endpackage

// File: rtl/spi_txq_fifo.sv
module spi_txq_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned CW    = spi_txq_pkg::occ_w(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] cnt_o,
  output logic          empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q, wptr_nx, rptr_nx;
  logic [CW-1:0] cnt_q;
  logic          full, push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full & ~clr_i;
  assign pop_ok  = pop_i & ~empty_o & ~clr_i;

  // pointer wrap: free-running for power-of-two depth, compare otherwise
  if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
    assign wptr_nx = wptr_q + 1'b1;
    assign rptr_nx = rptr_q + 1'b1;
  end else begin : g_wrap_cmp
    assign wptr_nx = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    assign rptr_nx = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_nx;
      if (pop_ok)  rptr_q <= rptr_nx;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rptr_q];
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/spi_txq_pacer.sv
module spi_txq_pacer
  import spi_txq_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned GAPW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            q_empty_i,
  input  logic [DW-1:0]   q_data_i,
  output logic            pop_o,
  input  logic [GAPW-1:0] gap_i,
  input  logic            done_i,
  input  logic            tick_i,
  output logic            ld_o,
  output logic [DW-1:0]   ld_data_o
);
  sh_state_e       sh_q;
  logic            hold_vld_q;
  logic [DW-1:0]   hold_q;
  logic [GAPW-1:0] gcnt_q;
  logic            sh_free;

  // shifter counts as free once its last bit is out (same-cycle done)
  assign sh_free = (sh_q == SH_IDLE) | done_i;
  assign pop_o   = ~hold_vld_q & ~q_empty_i & sh_free & ~clr_i;
  assign ld_o    = hold_vld_q & (sh_q == SH_IDLE) & (gcnt_q == '0) & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= SH_IDLE;
    end else if (ld_o) begin
      sh_q <= SH_BUSY;
    end else if (done_i) begin
      sh_q <= SH_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gcnt_q <= '0;
    end else if (clr_i) begin
      gcnt_q <= '0;
    end else if (done_i) begin
      gcnt_q <= gap_i;
    end else if (tick_i && gcnt_q != '0) begin
      gcnt_q <= gcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
    end else if (clr_i) begin
      hold_vld_q <= 1'b0;
    end else if (pop_o) begin
      hold_vld_q <= 1'b1;
      hold_q     <= q_data_i;
    end else if (ld_o) begin
      hold_vld_q <= 1'b0;
    end
  end

  assign ld_data_o = hold_q;
endmodule

// File: rtl/spi_txq_irq.sv
module spi_txq_irq #(
  parameter int unsigned CW = 5
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] lvl_i,
  input  logic          en_i,
  output logic          irq_o
);
  assign irq_o = en_i & (cnt_i <= lvl_i);
endmodule

// File: rtl/spi_txq.sv
module spi_txq #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned GAPW  = 8,
  parameter int unsigned CW    = spi_txq_pkg::occ_w(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            fifo_clr_i,
  input  logic [GAPW-1:0] gap_i,
  input  logic [CW-1:0]   trig_lvl_i,
  input  logic            irq_en_i,
  input  logic            shift_done_i,
  input  logic            sclk_tick_i,
  output logic            ld_o,
  output logic [DW-1:0]   ld_data_o,
  output logic [CW-1:0]   fill_o,
  output logic            irq_o
);
  logic          q_pop, q_empty;
  logic [DW-1:0] q_data;
  logic [CW-1:0] q_cnt;

  spi_txq_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fifo_clr_i),
    .push_i  (wr_en_i),
    .wdata_i (wr_data_i),
    .pop_i   (q_pop),
    .rdata_o (q_data),
    .cnt_o   (q_cnt),
    .empty_o (q_empty)
  );

  spi_txq_pacer #(.DW(DW), .GAPW(GAPW)) u_pacer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (fifo_clr_i),
    .q_empty_i (q_empty),
    .q_data_i  (q_data),
    .pop_o     (q_pop),
    .gap_i     (gap_i),
    .done_i    (shift_done_i),
    .tick_i    (sclk_tick_i),
    .ld_o      (ld_o),
    .ld_data_o (ld_data_o)
  );

  spi_txq_irq #(.CW(CW)) u_irq (
    .cnt_i (q_cnt),
    .lvl_i (trig_lvl_i),
    .en_i  (irq_en_i),
    .irq_o (irq_o)
  );

  assign fill_o = q_cnt;
endmodule

// File: rtl/spi_txq_chk.sv
module spi_txq_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned GAPW  = 8,
  parameter int unsigned CW    = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic            fifo_clr_i,
  input logic [GAPW-1:0] gap_i,
  input logic            irq_en_i,
  input logic            shift_done_i,
  input logic            ld_o,
  input logic [DW-1:0]   ld_data_o,
  input logic [CW-1:0]   fill_o,
  input logic            irq_o
);
  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fill_o) <= int'(DEPTH)); // R4

  AST_FILL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_clr_i |=> (int'(fill_o) <= int'($past(fill_o)) + 1) &&
                    (int'(fill_o) + 1 >= int'($past(fill_o)))); // R4

  AST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> (fill_o == '0) && !ld_o); // R8

  AST_ONE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o |=> !ld_o); // R5

  AST_GAP_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_done_i && gap_i != '0) |=> !ld_o); // R6

  AST_LD_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o |-> !$isunknown(ld_data_o)); // R2

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o); // R10

  AST_IRQ_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && fill_o == '0) |-> irq_o); // R9

  logic unused_wr;
  assign unused_wr = wr_en_i;
endmodule

bind spi_txq spi_txq_chk #(.DEPTH(DEPTH), .DW(DW), .GAPW(GAPW), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .fifo_clr_i   (fifo_clr_i),
  .gap_i        (gap_i),
  .irq_en_i     (irq_en_i),
  .shift_done_i (shift_done_i),
  .ld_o         (ld_o),
  .ld_data_o    (ld_data_o),
  .fill_o       (fill_o),
  .irq_o        (irq_o)
);

// File: tb/sim_spi_txq.sv
module sim_spi_txq;
  localparam int DEPTH = 16;
  localparam int DW    = 16;
  localparam int GAPW  = 8;
  localparam int CW    = 5;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            wr_en_i = 1'b0;
  logic [DW-1:0]   wr_data_i = '0;
  logic            fifo_clr_i = 1'b0;
  logic [GAPW-1:0] gap_i = '0;
  logic [CW-1:0]   trig_lvl_i = '0;
  logic            irq_en_i = 1'b0;
  logic            shift_done_i = 1'b0;
  logic            sclk_tick_i = 1'b0;
  logic            ld_o;
  logic [DW-1:0]   ld_data_o;
  logic [CW-1:0]   fill_o;
  logic            irq_o;

  spi_txq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .fifo_clr_i(fifo_clr_i), .gap_i(gap_i), .trig_lvl_i(trig_lvl_i),
    .irq_en_i(irq_en_i), .shift_done_i(shift_done_i), .sclk_tick_i(sclk_tick_i),
    .ld_o(ld_o), .ld_data_o(ld_data_o), .fill_o(fill_o), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;

  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  logic [DW-1:0] ref_q [$];
  bit          got_ld = 0;
  logic [DW-1:0] got_data = '0;
  bit          auto_sh = 0;
  int          sh_left = 0;
  bit          armed = 0;
  int          need = 0;
  int          ticks = 0;

  function automatic bit exp_irq(input bit en, input int fill, input int lvl);
    return en && (fill <= lvl);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog (R1..all): actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  // one cycle: settle, observe, update reference, wait for next negedge
  task automatic step();
    #1;
    got_ld   = ld_o;
    got_data = ld_data_o;
    chk(irq_o == exp_irq(irq_en_i, int'(fill_o), int'(trig_lvl_i)),
        irq_en_i ? "R9" : "R10", int'(irq_o),
        int'(exp_irq(irq_en_i, int'(fill_o), int'(trig_lvl_i))));
    chk(int'(fill_o) <= DEPTH, "R4", int'(fill_o), DEPTH);
    chk(ref_q.size() == int'(fill_o) || ref_q.size() == int'(fill_o) + 1,
        "R4", int'(fill_o), ref_q.size());
    if (ld_o) begin
      if (ref_q.size() == 0) chk(1'b0, "R2", int'(ld_data_o), 0);
      else begin
        chk(ld_data_o == ref_q[0], "R2", int'(ld_data_o), int'(ref_q[0]));
        void'(ref_q.pop_front());
      end
      if (armed) begin
        chk(ticks >= need, "R6", ticks, need);
        armed = 0;
      end
      sh_left = 1 + int'($urandom % 5);
    end
    if (shift_done_i) begin
      armed = 1; need = int'(gap_i); ticks = 0;
    end else if (armed && sclk_tick_i) ticks++;
    if (fifo_clr_i) begin
      ref_q.delete();
      armed = 0;
    end else if (wr_en_i && int'(fill_o) < DEPTH) ref_q.push_back(wr_data_i);
    @(negedge clk_i);
    if (auto_sh) begin
      if (sh_left > 0) begin
        sh_left--;
        shift_done_i = (sh_left == 0);
      end else shift_done_i = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    chk(fill_o == '0, "R1", int'(fill_o), 0);
    chk(!ld_o, "R1", int'(ld_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(fill_o == '0 && !ld_o, "R1", int'(fill_o), 0);

    // R2 / R7: two words, zero pause
    irq_en_i = 1'b1; gap_i = 8'd0; trig_lvl_i = 5'd0;
    wr_en_i = 1'b1; wr_data_i = 16'h1111; step();
    wr_data_i = 16'h2222; step();
    wr_en_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (got_ld) break;
    end
    chk(got_ld && got_data == 16'h1111, "R2", int'(got_data), 16'h1111);
    step(); chk(!got_ld, "R5", int'(got_ld), 0);
    step(); chk(!got_ld, "R5", int'(got_ld), 0);
    chk(fill_o == 5'd1, "R5", int'(fill_o), 1);
    shift_done_i = 1'b1; step();
    chk(!got_ld, "R7", int'(got_ld), 0);
    shift_done_i = 1'b0; step();
    chk(got_ld && got_data == 16'h2222, "R7", int'(got_data), 16'h2222);

    // R6: pause of three ticks
    wr_en_i = 1'b1; wr_data_i = 16'h3333; step();
    wr_en_i = 1'b0; step();
    gap_i = 8'd3; shift_done_i = 1'b1; step();
    shift_done_i = 1'b0;
    for (int i = 0; i < 2; i++) begin
      step(); chk(!got_ld, "R6", int'(got_ld), 0);
    end
    sclk_tick_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(); chk(!got_ld, "R6", int'(got_ld), 0);
    end
    sclk_tick_i = 1'b0; step();
    chk(got_ld && got_data == 16'h3333, "R6", int'(got_data), 16'h3333);

    // R3: overfill while the shifter is busy
    wr_en_i = 1'b1;
    for (int i = 0; i < 18; i++) begin
      wr_data_i = 16'h4000 + 16'(i); step();
    end
    wr_en_i = 1'b0;
    chk(fill_o == 5'd16, "R3", int'(fill_o), 16);
    chk(ref_q.size() == 16, "R3", ref_q.size(), 16);
    trig_lvl_i = 5'd16; #1;
    chk(irq_o == 1'b1, "R9", int'(irq_o), 1);
    trig_lvl_i = 5'd15; #1;
    chk(irq_o == 1'b0, "R9", int'(irq_o), 0);
    irq_en_i = 1'b0; trig_lvl_i = 5'd31; #1;
    chk(irq_o == 1'b0, "R10", int'(irq_o), 0);
    irq_en_i = 1'b1;
    auto_sh = 1; gap_i = 8'd1; sclk_tick_i = 1'b1;
    for (int i = 0; i < 250; i++) step();
    chk(fill_o == '0 && ref_q.size() == 0, "R3", int'(fill_o), 0);
    auto_sh = 0; sclk_tick_i = 1'b0; gap_i = 8'd0; shift_done_i = 1'b0;

    // R8: flush cancels a long pause and the holding word
    wr_en_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      wr_data_i = 16'h6000 + 16'(i); step();
    end
    wr_en_i = 1'b0;
    for (int i = 0; i < 3; i++) step();
    gap_i = 8'd200; shift_done_i = 1'b1; step();
    shift_done_i = 1'b0; step();
    fifo_clr_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 16'hDEAD; step();
    chk(fill_o == '0, "R8", int'(fill_o), 0);
    step(); step();
    chk(fill_o == '0 && !ld_o, "R8", int'(fill_o), 0);
    fifo_clr_i = 1'b0; wr_en_i = 1'b0; step();
    wr_en_i = 1'b1; wr_data_i = 16'h5555; step();
    wr_en_i = 1'b0;
    got_ld = 0;
    for (int i = 0; i < 5; i++) begin
      step();
      if (got_ld) break;
    end
    chk(got_ld && got_data == 16'h5555, "R8", int'(got_data), 16'h5555);

    // random mix
    auto_sh = 1;
    for (int i = 0; i < 3000; i++) begin
      if (i % 50 == 0) begin
        gap_i      = GAPW'($urandom % 5);
        trig_lvl_i = CW'($urandom % 32);
        irq_en_i   = ($urandom % 4) != 0;
      end
      wr_en_i     = ($urandom % 10) < 4;
      wr_data_i   = DW'($urandom);
      fifo_clr_i  = ($urandom % 200) == 0;
      sclk_tick_i = $urandom % 2;
      step();
    end
    auto_sh = 0;
    summary();
    $finish;
  end
endmodule